// File: doc/BRIEF.md
# Floating-Point Exception Status Recorder

After a floating-point operation completes, this block folds the operation's IEEE exception flags into the floating-point status word. The caller raises `opDone` for one cycle. With it the caller presents the five exception flags the operation produced and the status word as it stood before the operation. On the next clock edge the block publishes the rewritten status word. It also emits exactly one single-cycle pulse. That pulse is either a trap request, meaning some raised flag is enabled for trapping, or an advance-PC pulse, meaning execution may continue with the next instruction.

When a trap is taken, the current-exception field is reduced to one flag. Only flags enabled in the trap-enable field are considered, and the survivor is chosen by a fixed priority. The accrued field is left alone, and the trap-type field records an IEEE exception. When no trap is taken, all raised flags go into the current field and are also ORed into the accrued field. An operation that raises no flags therefore clears the current field and advances the PC.

The flag vector uses these bit positions: invalid = bit 4, overflow = bit 3, underflow = bit 2, divide-by-zero = bit 1, inexact = bit 0. The status word must be at least 28 bits wide.

Top module: `fpx_status_recorder`

## Requirements
- R1: On the edge after `opDone`, `trapReq` is high exactly when the AND of `excFlags` with the trap-enable field (status bits 27:23, same bit order as the flags) is nonzero.
- R2: On a trap, status bits 4:0 (current field) hold exactly one flag. That flag is the highest-priority bit of (`excFlags` AND enable mask), with priority invalid (bit 4) > overflow (3) > underflow (2) > divide-by-zero (1) > inexact (0).
- R3: Without a trap, status bits 4:0 equal `excFlags` unchanged, so zero flags clear the field.
- R4: Without a trap, status bits 9:5 (accrued field) become the previous accrued value ORed with `excFlags`. On a trap they keep the value from `statusIn`.
- R5: On a trap, status bits 16:14 (trap type) are written with 1. Without a trap they keep the value from `statusIn`.
- R6: All status bits outside 4:0, 9:5 and 16:14 are copied from `statusIn` unchanged.
- R7: Without a trap, including the case of no flags at all, `advancePc` pulses high on the edge after `opDone`.
- R8: `trapReq` and `advancePc` are one-cycle pulses, never high together, and exactly one of them follows each `opDone`.
- R9: In a cycle without `opDone`, `statusOut` holds its value and neither pulse is raised on the following edge, whatever `excFlags` and `statusIn` carry.
- R10: After reset, `statusOut` is zero and both pulses are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| opDone | input | 1 | One-cycle strobe: an operation has completed |
| excFlags | input | 5 | Exception flags raised by the operation |
| statusIn | input | STATUS_W | Status word before the operation |
| statusOut | output | STATUS_W | Rewritten status word, registered |
| trapReq | output | 1 | Pulse: an enabled exception requires a trap |
| advancePc | output | 1 | Pulse: no trap, move to the next instruction |

## Verification
The bench builds the block with the default 32-bit status word. In that configuration every one of the 1024 combinations of exception flags and trap-enable mask can be applied, so every priority collision is exercised, along with every trap versus no-trap decision and the all-zero flag case. Each combination is repeated over several background patterns in the accrued, trap-type and unrelated bits. Those patterns show that only the named fields move. An idle cycle with changing inputs follows every operation to show that nothing is taken up without the strobe.

// File: rtl/fpx_pkg.sv
package fpx_pkg;
  localparam int FLAG_W     = 5;
  localparam int CEXC_LSB   = 0;
  localparam int AEXC_LSB   = 5;
  localparam int TTYPE_LSB  = 14;
  localparam int TTYPE_W    = 3;
  localparam int TEM_LSB    = 23;
  localparam int MIN_STATUS = TEM_LSB + FLAG_W;
  localparam logic [TTYPE_W-1:0] TTYPE_IEEE = 3'd1;

  // Strobes from control to datapath
  typedef struct packed {
    logic load;
    logic trap;
  } fpxStrobe_t;

  // Keep only the highest-priority set bit (bit FLAG_W-1 is highest)
  function automatic logic [FLAG_W-1:0] keepTopFlag(input logic [FLAG_W-1:0] v);
    logic [FLAG_W-1:0] r;
    logic found;
    r = '0;
    found = 1'b0;
    for (int i = FLAG_W - 1; i >= 0; i--) begin
      if (v[i] && !found) begin
        r[i] = 1'b1;
        found = 1'b1;
      end
    end
    return r;
  endfunction
endpackage

// File: rtl/fpx_ctrl.sv
module fpx_ctrl
  import fpx_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              opDone,
  input  logic [FLAG_W-1:0] excFlags,
  input  logic [FLAG_W-1:0] temMask,
  output fpxStrobe_t        strobe,
  output logic              trapReq,
  output logic              advancePc
);
  logic trapHit;

  assign trapHit     = |(excFlags & temMask);
  assign strobe.load = opDone;
  assign strobe.trap = opDone && trapHit;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      trapReq   <= 1'b0;
      advancePc <= 1'b0;
    end else begin
      trapReq   <= opDone && trapHit;
      advancePc <= opDone && !trapHit;
    end
  end
endmodule

// File: rtl/fpx_datapath.sv
module fpx_datapath
  import fpx_pkg::*;
#(
  parameter int STATUS_W = 32
) (
  input  logic                clk,
  input  logic                rstN,
  input  fpxStrobe_t          strobe,
  input  logic [FLAG_W-1:0]   excFlags,
  input  logic [STATUS_W-1:0] statusIn,
  output logic [STATUS_W-1:0] statusOut
);
  logic [FLAG_W-1:0]   temMask;
  logic [FLAG_W-1:0]   enabledFlags;
  logic [FLAG_W-1:0]   curFlags;
  logic [FLAG_W-1:0]   oldAccrued;
  logic [STATUS_W-1:0] statusNext;

  assign temMask      = statusIn[TEM_LSB +: FLAG_W];
  assign enabledFlags = excFlags & temMask;
  assign oldAccrued   = statusIn[AEXC_LSB +: FLAG_W];
  assign curFlags     = strobe.trap ? keepTopFlag(enabledFlags) : excFlags;

  always_comb begin
    statusNext = statusIn;
    statusNext[CEXC_LSB +: FLAG_W] = curFlags;
    if (strobe.trap) begin
      statusNext[TTYPE_LSB +: TTYPE_W] = TTYPE_IEEE;
    end else begin
      statusNext[AEXC_LSB +: FLAG_W] = oldAccrued | curFlags;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      statusOut <= '0;
    end else if (strobe.load) begin
      statusOut <= statusNext;
    end
  end
endmodule

// File: rtl/fpx_status_recorder.sv
module fpx_status_recorder
  import fpx_pkg::*;
#(
  parameter int STATUS_W = 32
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                opDone,
  input  logic [4:0]          excFlags,
  input  logic [STATUS_W-1:0] statusIn,
  output logic [STATUS_W-1:0] statusOut,
  output logic                trapReq,
  output logic                advancePc
);
  fpxStrobe_t strobe;

  fpx_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .opDone    (opDone),
    .excFlags  (excFlags),
    .temMask   (statusIn[TEM_LSB +: FLAG_W]),
    .strobe    (strobe),
    .trapReq   (trapReq),
    .advancePc (advancePc)
  );

  fpx_datapath #(.STATUS_W(STATUS_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .excFlags  (excFlags),
    .statusIn  (statusIn),
    .statusOut (statusOut)
  );
endmodule

// File: rtl/fpx_status_checker.sv
module fpx_status_checker #(
  parameter int STATUS_W = 32
) (
  input logic                clk,
  input logic                rstN,
  input logic                opDone,
  input logic [4:0]          excFlags,
  input logic [STATUS_W-1:0] statusIn,
  input logic [STATUS_W-1:0] statusOut,
  input logic                trapReq,
  input logic                advancePc
);
  p_pulse_exclusive_r8: assert property (@(posedge clk) disable iff (!rstN)
    !(trapReq && advancePc));

  p_one_response_r8: assert property (@(posedge clk) disable iff (!rstN)
    opDone |=> (trapReq ^ advancePc));

  p_quiet_idle_r9: assert property (@(posedge clk) disable iff (!rstN)
    !opDone |=> (!trapReq && !advancePc && $stable(statusOut)));

  p_trap_decision_r1: assert property (@(posedge clk) disable iff (!rstN)
    opDone |=> (trapReq == (|($past(excFlags) & $past(statusIn[27:23])))));

  p_single_flag_r2: assert property (@(posedge clk) disable iff (!rstN)
    trapReq |-> ($countones(statusOut[4:0]) == 1));

  p_cexc_copy_r3: assert property (@(posedge clk) disable iff (!rstN)
    advancePc |-> (statusOut[4:0] == $past(excFlags)));

  p_accrued_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    trapReq |-> (statusOut[9:5] == $past(statusIn[9:5])));

  p_trap_type_r5: assert property (@(posedge clk) disable iff (!rstN)
    trapReq |-> (statusOut[16:14] == 3'd1));
endmodule

bind fpx_status_recorder fpx_status_checker #(.STATUS_W(STATUS_W)) u_chk (.*);

// File: tb/sim_fpx_status_recorder.sv
`timescale 1ns/1ps
module sim_fpx_status_recorder;
  localparam int W = 32;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         opDone = 1'b0;
  logic [4:0]   excFlags = '0;
  logic [W-1:0] statusIn = '0;
  logic [W-1:0] statusOut;
  logic         trapReq;
  logic         advancePc;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  fpx_status_recorder #(.STATUS_W(W)) u0 (
    .clk(clk), .rstN(rstN), .opDone(opDone), .excFlags(excFlags),
    .statusIn(statusIn), .statusOut(statusOut),
    .trapReq(trapReq), .advancePc(advancePc)
  );

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Highest set bit as a power of two, computed arithmetically
  function automatic int topPow(input int v);
    int p;
    p = 0;
    for (int b = 1; b <= 16; b = b * 2) if (v >= b) p = b;
    return p;
  endfunction

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!finished) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin : stim
    logic [W-1:0] held;
    repeat (3) @(negedge clk);
    // R10 reset state
    check("R10 status", statusOut, '0);
    check("R10 pulses", {30'd0, trapReq, advancePc}, '0);
    rstN = 1'b1;

    for (int k = 0; k < 4; k++) begin
      for (int t = 0; t < 32; t++) begin
        for (int f = 0; f < 32; f++) begin
          logic [W-1:0] bg, sIn, expS;
          int masked, cur;
          logic expTrap;
          bg = 32'hA5C3_0F96 ^ (32'(k) * 32'h9E37_79B9) ^ (32'(f * 7 + t) << 5);
          sIn = bg;
          sIn[27:23] = 5'(t);
          masked = f & t;
          expTrap = (masked != 0);
          cur = expTrap ? topPow(masked) : f;
          expS = sIn;
          expS[4:0] = 5'(cur);
          if (expTrap) expS[16:14] = 3'd1;
          else expS[9:5] = sIn[9:5] | 5'(f);

          @(negedge clk);
          opDone = 1'b1;
          excFlags = 5'(f);
          statusIn = sIn;
          @(negedge clk);
          opDone = 1'b0;
          excFlags = ~5'(f);
          statusIn = ~sIn;
          check("R1 trapReq", {31'd0, trapReq}, {31'd0, expTrap});
          check("R7 advancePc", {31'd0, advancePc}, {31'd0, !expTrap});
          check(expTrap ? "R2 current field" : "R3 current field",
                {27'd0, statusOut[4:0]}, {27'd0, expS[4:0]});
          check("R4 accrued field", {27'd0, statusOut[9:5]}, {27'd0, expS[9:5]});
          check("R5 trap type", {29'd0, statusOut[16:14]}, {29'd0, expS[16:14]});
          check("R6 other bits", statusOut & 32'hFFFE_3C00, expS & 32'hFFFE_3C00);
          held = statusOut;
          @(negedge clk);
          // R8 pulse width, R9 idle cycle with changed inputs
          check("R8 pulses end", {30'd0, trapReq, advancePc}, '0);
          check("R9 status held", statusOut, held);
        end
      end
    end
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule